// File: doc/BRIEF.md
# Cascadable Serial Crosspoint Configuration Loader

This block takes the configuration of an eight-output video crosspoint as a serial bit stream and turns it into per-output control: a 3-bit input select, a ground flag and a buffer enable. Bits enter a 32-bit first-rank shift register one per accepted beat. The oldest bit of that register is always presented on a cascade pin, so a second loader that receives the same beats sees the bits that have been pushed out of the first. A frame holds eight 4-bit codes. The code for output 0 is sent first and the code for output 7 is sent last. Each code is sent with its most significant bit first.

A separate latch pin copies the whole first rank into the second rank, where each code is decoded. In edge mode the copy happens on a rising edge of the latch pin. In level mode the second rank follows the first rank for as long as the latch pin is low. Codes 1011 to 1111 are illegal. If any field holds one of them, the whole copy is refused and an error flag is raised.

The serial input is a valid/ready port. `s_ready` is the combination of the two chip-enable pins and never depends on anything else, so the only back-pressure is a deasserted chip enable. A beat is taken on every clock where `s_valid` and `s_ready` are both high. The cascade pin has no handshake. It is meant to feed a downstream loader that is clocked by the same accepted beats.

Top module: `xpt_serial_loader`

## Requirements
- R1: After 32 accepted bits and a transfer, output k takes the code carried by accepted bits 4k to 4k+3 of the frame, counted from 0, with that code's bit 3 arriving first.
- R2: `s_ready` is high exactly when `cs` is 1 and `cs_n` is 0. A bit offered while `s_ready` is low leaves the first rank unchanged.
- R3: `casc_bit` shows the bit accepted 32 acceptances earlier. It changes only on a cycle where a bit is accepted.
- R4: A transferred code 0000 to 0111 sets `sel_o[3k+2:3k]` to the code's low three bits and clears `gnd_o[k]`. It leaves `en_o[k]` unchanged.
- R5: A transferred code 1000 sets `gnd_o[k]`, zeroes the select and leaves `en_o[k]` unchanged.
- R6: A transferred code 1001 sets `en_o[k]` and `gnd_o[k]` and zeroes the select.
- R7: A transferred code 1010 clears `en_o[k]`, sets `gnd_o[k]` and zeroes the select.
- R8: A transfer attempt with any field in the range 1011 to 1111 changes no output and sets `err_o`. The next valid transfer clears `err_o`.
- R9: With `edge_mode` = 1, a transfer happens only on a clock where `latch_i` is sampled high after being sampled low on the previous clock. The first clock after reset counts as following a high sample.
- R10: With `edge_mode` = 0, a transfer happens on every clock where `latch_i` is low, and the outputs hold while it is high.
- R11: After reset, every output is disabled and grounded with select 0, `err_o` is 0 and the first rank is all zero.
- R12: When a bit is accepted on the same clock as a transfer, the transfer uses the first-rank contents from before that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Active-high chip enable |
| cs_n | input | 1 | Active-low chip enable |
| s_valid | input | 1 | Serial bit offered |
| s_ready | output | 1 | Serial bit can be taken |
| s_bit | input | 1 | Serial data bit |
| casc_bit | output | 1 | Oldest first-rank bit, for a cascaded loader |
| latch_i | input | 1 | Transfer strobe to the second rank |
| edge_mode | input | 1 | 1: rising-edge transfer, 0: transparent while low |
| sel_o | output | 24 | Input select, 3 bits per output, output k at [3k+2:3k] |
| gnd_o | output | 8 | Buffer input grounded, one bit per output |
| en_o | output | 8 | Buffer enabled, one bit per output |
| err_o | output | 1 | Last transfer attempt was refused |

## Verification
The main overlap is a bit being accepted on the same clock that a transfer fires. If the second rank sampled the register after the shift, every field would be misaligned by one bit. The bench raises the latch pin on the very beat that carries a new bit and expects the second rank to show the previous full frame. A later transfer must then show that frame shifted left by one bit. Level mode is also run with shifting under a low latch, where a transfer happens on every beat. The bench's cycle model predicts each intermediate second-rank state, including enables that pass through on misaligned fields and refusals caused by illegal fields.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int SEL_W  = 3;
  localparam int CODE_W = SEL_W + 1;

  localparam logic [CODE_W-1:0] CMD_GND = 4'b1000;
  localparam logic [CODE_W-1:0] CMD_ON  = 4'b1001;
  localparam logic [CODE_W-1:0] CMD_OFF = 4'b1010;

  // A control code (top bit set) is legal only up to the disable code.
  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return !c[CODE_W-1] || (c[SEL_W-1:0] <= CMD_OFF[SEL_W-1:0]);
  endfunction
endpackage

// File: rtl/xpt_shift_chain.sv
module xpt_shift_chain
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_i,
  input  logic                      bit_i,
  output logic [N_OUT*CODE_W-1:0]   word_o,
  output logic                      casc_o
);
  localparam int FRAME_W = N_OUT * CODE_W;

  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (acc_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end

  assign word_o = sr_q;
  assign casc_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/xpt_latch_ctrl.sv
module xpt_latch_ctrl
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      latch_i,
  input  logic                      edge_mode,
  input  logic [N_OUT*CODE_W-1:0]   word_i,
  output logic                      load_o,
  output logic                      err_o
);
  localparam int FRAME_W = N_OUT * CODE_W;

  logic             prev_q;
  logic             err_q;
  logic             strobe;
  logic [N_OUT-1:0] field_ok;

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
      assign field_ok[k] = code_ok(word_i[FRAME_W-1-k*CODE_W -: CODE_W]);
    end
  endgenerate

  assign strobe = edge_mode ? (latch_i && !prev_q) : !latch_i;
  assign load_o = strobe && (&field_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      prev_q <= latch_i;
      if (strobe) err_q <= !(&field_ok);
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/xpt_out_slot.sv
module xpt_out_slot
  import xpt_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              gnd_o,
  output logic              en_o
);
  logic [CODE_W-1:0] code_q;
  logic              en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CMD_GND;
      en_q   <= 1'b0;
    end else if (load_i) begin
      code_q <= code_i;
      if (code_i == CMD_ON)       en_q <= 1'b1;
      else if (code_i == CMD_OFF) en_q <= 1'b0;
    end
  end

  assign gnd_o = code_q[CODE_W-1];
  assign sel_o = code_q[CODE_W-1] ? '0 : code_q[SEL_W-1:0];
  assign en_o  = en_q;
endmodule

// File: rtl/xpt_serial_loader.sv
module xpt_serial_loader
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs,
  input  logic                   cs_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic                   s_bit,
  output logic                   casc_bit,
  input  logic                   latch_i,
  input  logic                   edge_mode,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       gnd_o,
  output logic [N_OUT-1:0]       en_o,
  output logic                   err_o
);
  localparam int FRAME_W = N_OUT * CODE_W;

  logic               accept;
  logic               load;
  logic [FRAME_W-1:0] word;

  assign s_ready = cs && !cs_n;
  assign accept  = s_valid && s_ready;

  xpt_shift_chain #(.N_OUT(N_OUT)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_i  (accept),
    .bit_i  (s_bit),
    .word_o (word),
    .casc_o (casc_bit)
  );

  xpt_latch_ctrl #(.N_OUT(N_OUT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_i   (latch_i),
    .edge_mode (edge_mode),
    .word_i    (word),
    .load_o    (load),
    .err_o     (err_o)
  );

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_slot
      xpt_out_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .code_i (word[FRAME_W-1-k*CODE_W -: CODE_W]),
        .sel_o  (sel_o[k*SEL_W +: SEL_W]),
        .gnd_o  (gnd_o[k]),
        .en_o   (en_o[k])
      );
    end
  endgenerate
endmodule

// File: rtl/xpt_serial_loader_chk.sv
module xpt_serial_loader_chk
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic                   casc_bit,
  input logic                   latch_i,
  input logic                   edge_mode,
  input logic [N_OUT*SEL_W-1:0] sel_o,
  input logic [N_OUT-1:0]       gnd_o,
  input logic [N_OUT-1:0]       en_o,
  input logic                   err_o
);
  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(casc_bit));

  // R8
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($stable(sel_o) && $stable(gnd_o) && $stable(en_o)));

  // R9
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && latch_i && $past(latch_i)) |=>
      ($stable(sel_o) && $stable(gnd_o) && $stable(en_o)));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && latch_i) |=>
      ($stable(sel_o) && $stable(gnd_o) && $stable(en_o) && $stable(err_o)));

  // R11
  reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_o == '0 && gnd_o == '1 && !err_o));
endmodule

bind xpt_serial_loader xpt_serial_loader_chk #(.N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .casc_bit  (casc_bit),
  .latch_i   (latch_i),
  .edge_mode (edge_mode),
  .sel_o     (sel_o),
  .gnd_o     (gnd_o),
  .en_o      (en_o),
  .err_o     (err_o)
);

// File: tb/xpt_serial_loader_bench.sv
module xpt_serial_loader_bench;
  localparam int PERIOD = 10;
  localparam int NO     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, cs_n = 1'b0;
  logic s_valid = 1'b0, s_bit = 1'b0;
  logic latch_i = 1'b1, edge_mode = 1'b1;
  logic s_ready, casc_bit, err_o;
  logic [NO*3-1:0] sel_o;
  logic [NO-1:0]   gnd_o, en_o;

  int checks = 0;
  int errors = 0;

  // cycle model built from the requirements
  logic [31:0] m_sr;
  logic        m_prev, m_err;
  logic [3:0]  m_code [NO];
  logic [NO-1:0] m_en;

  always #(PERIOD/2) clk = ~clk;

  xpt_serial_loader u_xpt_serial_loader (
    .clk(clk), .rst_n(rst_n), .cs(cs), .cs_n(cs_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .casc_bit(casc_bit), .latch_i(latch_i), .edge_mode(edge_mode),
    .sel_o(sel_o), .gnd_o(gnd_o), .en_o(en_o), .err_o(err_o)
  );

  function automatic logic legal(input logic [3:0] c);
    return !c[3] || c[2:0] <= 3'd2;
  endfunction

  task automatic model_reset();
    m_sr = '0; m_prev = 1'b1; m_err = 1'b0; m_en = '0;
    for (int k = 0; k < NO; k++) m_code[k] = 4'b1000;
  endtask

  // one clock: drive at the falling edge, update the model, wait a cycle
  task automatic cyc(input logic v, input logic b, input logic l);
    logic xfer, ok;
    s_valid = v; s_bit = b; latch_i = l;
    xfer = edge_mode ? (l && !m_prev) : !l;
    if (xfer) begin
      ok = 1'b1;
      for (int k = 0; k < NO; k++) ok &= legal(m_sr[31-4*k -: 4]);
      if (ok) begin
        for (int k = 0; k < NO; k++) begin
          m_code[k] = m_sr[31-4*k -: 4];
          if (m_code[k] == 4'b1001) m_en[k] = 1'b1;
          if (m_code[k] == 4'b1010) m_en[k] = 1'b0;
        end
      end
      m_err = !ok;
    end
    m_prev = l;
    if (v && cs && !cs_n) m_sr = {m_sr[30:0], b};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input string req);
    logic [NO*3-1:0] es;
    logic [NO-1:0]   eg;
    for (int k = 0; k < NO; k++) begin
      eg[k] = m_code[k][3];
      es[k*3 +: 3] = m_code[k][3] ? 3'd0 : m_code[k][2:0];
    end
    checks++;
    if ({sel_o, gnd_o, en_o, err_o} !== {es, eg, m_en, m_err}) begin
      errors++;
      $display("FAIL %s sel/gnd/en/err actual %h/%h/%h/%b expected %h/%h/%h/%b",
               req, sel_o, gnd_o, en_o, err_o, es, eg, m_en, m_err);
    end
  endtask

  task automatic chk_casc(input string req);
    checks++;
    if (casc_bit !== m_sr[31]) begin
      errors++;
      $display("FAIL %s casc_bit actual %b expected %b", req, casc_bit, m_sr[31]);
    end
  endtask

  task automatic send(input logic [31:0] f);
    for (int i = 31; i >= 0; i--) cyc(1'b1, f[i], latch_i);
  endtask

  task automatic pulse();
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  function automatic logic [31:0] mk(input int base, input int step);
    logic [31:0] f;
    for (int k = 0; k < NO; k++) f[31-4*k -: 4] = 4'((base + k*step) % 11);
    return f;
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk_out("R11");
    chk_casc("R11");
    checks++;
    if (s_ready !== 1'b1) begin errors++; $display("FAIL R2 s_ready actual %b expected 1", s_ready); end

    // R1 R4 R5 R6 R7: sweep of every legal code over every position
    for (int c = 0; c < 16; c++) begin
      send(mk(c, 3));
      pulse();
      chk_out("R1/R4/R5/R6/R7");
    end
    send({8{4'b1001}}); pulse(); chk_out("R6");
    send({4'b0101, 4'b1000, 4'b0111, 4'b1000, 4'b0000, 4'b1000, 4'b0011, 4'b1000});
    pulse(); chk_out("R4/R5 enable kept");
    send({8{4'b1010}}); pulse(); chk_out("R7");

    // R8: each illegal code in each field
    for (int bad = 11; bad < 16; bad++) begin
      for (int p = 0; p < NO; p++) begin
        logic [31:0] f;
        f = mk(bad + p, 1);
        f[31-4*p -: 4] = 4'(bad);
        send(f); pulse(); chk_out("R8 refused");
        checks++;
        if (err_o !== 1'b1) begin errors++; $display("FAIL R8 err_o actual %b expected 1", err_o); end
        send(mk(p, 2)); pulse(); chk_out("R8 cleared");
      end
    end

    // R3: cascade output replays the previous frame in order
    send(32'hA5C3_0F96);
    for (int i = 31; i >= 0; i--) begin
      chk_casc("R3");
      cyc(1'b1, 1'(i % 2), 1'b1);
    end
    chk_casc("R3 hold");
    cyc(1'b0, 1'b1, 1'b1);
    chk_casc("R3 hold");

    // R2: beats offered while chip enable is off are ignored
    send(mk(4, 5));
    cs = 1'b0;
    @(negedge clk);
    checks++;
    if (s_ready !== 1'b0) begin errors++; $display("FAIL R2 s_ready actual %b expected 0", s_ready); end
    send(32'hFFFF_FFFF);
    chk_casc("R2");
    pulse(); chk_out("R2");
    cs = 1'b1; cs_n = 1'b1;
    send(32'hBBBB_BBBB); pulse(); chk_out("R2 cs_n");
    cs_n = 1'b0;

    // R9: latch held high or low gives no further transfer
    send(mk(7, 4));
    cyc(1'b0, 1'b0, 1'b1); chk_out("R9 high hold");
    cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0); chk_out("R9 low hold");
    cyc(1'b0, 1'b0, 1'b1); chk_out("R9 edge");

    // R12: bit accepted on the transfer clock
    send(32'h9012_3456);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1); chk_out("R12 pre-shift word");
    pulse(); chk_out("R12 shifted word");

    // R10: level mode transparency and hold
    edge_mode = 1'b0;
    send(mk(2, 7));
    chk_out("R10 high hold");
    cyc(1'b0, 1'b0, 1'b0); chk_out("R10 low transfer");
    for (int i = 31; i >= 0; i--) begin
      cyc(1'b1, 1'(({i[3:0], 4'h9} >> (i % 8)) & 1), 1'b0);
      chk_out("R10 transparent");
    end
    cyc(1'b0, 1'b0, 1'b1);
    send(mk(9, 1));
    chk_out("R10 hold while high");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule